// File: doc/BRIEF.md
# Fractional multiply-accumulate unit

This block is the multiply-accumulate datapath of a small fixed-point DSP. It holds two 16-bit signed operand registers X and Y, a 32-bit product register P and a 32-bit accumulator A. The product is kept in fractional format: P always equals the signed product of X and Y, shifted left by one bit and kept modulo 2^32. Writing either operand register recomputes P in the same step.

There are three multiply commands. Each loads X and Y from two data-RAM read ports and forms a new product from them. In the same step, the accumulator is either cleared, increased by the old product, or decreased by the old product. This lets a filter tap loop issue one command per cycle. The block also owns a 16-bit status register. The multiply commands rewrite only its top four flag bits. A separate command loads the whole status register.

All state is registered. One command is accepted per clock and takes effect at that rising edge.

Top module: `fmac_unit`

## Requirements
- R1: A synchronous active-high `rst` clears X, Y, P, A and the status register to zero.
- R2: Command 1 loads X from `wr_data` and sets P to (new X times current Y times 2), computed on signed 16-bit operands and truncated to 32 bits. Y keeps its value.
- R3: Command 2 loads Y from `wr_data` and sets P to (current X times new Y times 2). X keeps its value.
- R4: Command 3 loads X from `rd_a` and Y from `rd_b` and sets P to their doubled product. It sets A to 0 and sets the status flags to N=0, OV=0, Z=1, L=0.
- R5: Command 4 sets A to A plus the P value held before the edge. In the same step it loads X and Y from `rd_a` and `rd_b` and forms the new doubled product in P.
- R6: Command 5 behaves like command 4, except that A becomes A minus the old P.
- R7: After commands 4 and 5, the status flags are set as follows:
  - bit 15 (N) is bit 31 of the new A;
  - bit 14 (OV) is signed overflow of the 32-bit add or subtract;
  - bit 13 (Z) is set when the new A is zero;
  - bit 12 (L) is the carry out of the add or the borrow of the subtract.
- R8: Commands 3, 4 and 5 leave status bits 11 to 0 unchanged.
- R9: Command 6 loads the whole status register from `wr_data`. Commands 0 and 7 change no state.
- R10: The operand pair -32768 by -32768 yields P = 0x80000000, because the doubled product wraps to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_code | input | 3 | Command: 0 idle, 1 write X, 2 write Y, 3 clear and multiply, 4 add and multiply, 5 subtract and multiply, 6 load status, 7 idle |
| wr_data | input | 16 | Data for commands 1, 2 and 6 |
| rd_a | input | 16 | First RAM operand, loaded into X by commands 3 to 5 |
| rd_b | input | 16 | Second RAM operand, loaded into Y by commands 3 to 5 |
| x_q | output | 16 | Operand register X |
| y_q | output | 16 | Operand register Y |
| p_q | output | 32 | Doubled product register P |
| acc_q | output | 32 | Accumulator A |
| st_q | output | 16 | Status register: flags in bits 15 to 12, other bits held |

## Verification
In commands 4 and 5, the accumulator update and the new product fall in the same clock. The sum must use the product registered before the edge, while P is overwritten with the product of the fresh RAM operands. The bench provokes this with runs of back-to-back add and subtract commands whose operands change every cycle, including a run with random operands. The scoreboard model holds the old P separately from the new one, so any design that feeds the fresh product into the sum shows up as a mismatch in A and in the flags.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_WRX  = 3'd1,
    OP_WRY  = 3'd2,
    OP_MCLR = 3'd3,
    OP_MADD = 3'd4,
    OP_MSUB = 3'd5,
    OP_WRST = 3'd6,
    OP_IDLE = 3'd7
  } op_e;

  localparam int STW   = 16;
  localparam int FLG_N = 15;
  localparam int FLG_V = 14;
  localparam int FLG_Z = 13;
  localparam int FLG_L = 12;
endpackage

// File: rtl/fmac_mult.sv
module fmac_mult #(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic [AW-1:0] prod
);
  logic signed [AW-1:0] raw;

  // Full signed product, then the fractional doubling shift.
  assign raw  = $signed(op_a) * $signed(op_b);
  assign prod = {raw[AW-2:0], 1'b0};
endmodule

// File: rtl/fmac_addsub.sv
module fmac_addsub #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] lhs,
  input  logic [AW-1:0] rhs,
  input  logic          do_sub,
  output logic [AW-1:0] res,
  output logic          neg,
  output logic          ovf,
  output logic          zero,
  output logic          cry
);
  logic [AW:0] wide;

  assign wide = do_sub ? ({1'b0, lhs} - {1'b0, rhs})
                       : ({1'b0, lhs} + {1'b0, rhs});
  assign res  = wide[AW-1:0];
  assign cry  = wide[AW];
  assign neg  = res[AW-1];
  assign zero = (res == '0);

  always_comb begin
    if (do_sub)
      ovf = (lhs[AW-1] != rhs[AW-1]) && (res[AW-1] != lhs[AW-1]);
    else
      ovf = (lhs[AW-1] == rhs[AW-1]) && (res[AW-1] != lhs[AW-1]);
  end
endmodule

// File: rtl/fmac_unit.sv
module fmac_unit
  import fmac_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    op_code,
  input  logic [DW-1:0] wr_data,
  input  logic [DW-1:0] rd_a,
  input  logic [DW-1:0] rd_b,
  output logic [DW-1:0] x_q,
  output logic [DW-1:0] y_q,
  output logic [AW-1:0] p_q,
  output logic [AW-1:0] acc_q,
  output logic [STW-1:0] st_q
);
  op_e           op;
  logic          is_mul;
  logic [DW-1:0] x_nx, y_nx;
  logic [AW-1:0] prod_nx;
  logic [AW-1:0] sum_res;
  logic          f_n, f_v, f_z, f_l;

  assign op     = op_e'(op_code);
  assign is_mul = (op == OP_MCLR) || (op == OP_MADD) || (op == OP_MSUB);

  // Operand values after this edge; the product follows them.
  always_comb begin
    x_nx = x_q;
    y_nx = y_q;
    if (op == OP_WRX) x_nx = wr_data;
    if (op == OP_WRY) y_nx = wr_data;
    if (is_mul) begin
      x_nx = rd_a;
      y_nx = rd_b;
    end
  end

  fmac_mult #(.DW(DW)) mult_i (
    .op_a (x_nx),
    .op_b (y_nx),
    .prod (prod_nx)
  );

  // Accumulate always uses the registered (old) product.
  fmac_addsub #(.AW(AW)) addsub_i (
    .lhs    (acc_q),
    .rhs    (p_q),
    .do_sub (op == OP_MSUB),
    .res    (sum_res),
    .neg    (f_n),
    .ovf    (f_v),
    .zero   (f_z),
    .cry    (f_l)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q   <= '0;
      y_q   <= '0;
      p_q   <= '0;
      acc_q <= '0;
      st_q  <= '0;
    end else begin
      if (op == OP_WRX || op == OP_WRY || is_mul) begin
        x_q <= x_nx;
        y_q <= y_nx;
        p_q <= prod_nx;
      end
      case (op)
        OP_MCLR: begin
          acc_q <= '0;
          st_q[FLG_N] <= 1'b0;
          st_q[FLG_V] <= 1'b0;
          st_q[FLG_Z] <= 1'b1;
          st_q[FLG_L] <= 1'b0;
        end
        OP_MADD, OP_MSUB: begin
          acc_q <= sum_res;
          st_q[FLG_N] <= f_n;
          st_q[FLG_V] <= f_v;
          st_q[FLG_Z] <= f_z;
          st_q[FLG_L] <= f_l;
        end
        OP_WRST: st_q <= STW'(wr_data);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fmac_unit_chk.sv
module fmac_unit_chk
  import fmac_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    op_code,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] rd_a,
  input logic [DW-1:0] rd_b,
  input logic [DW-1:0] x_q,
  input logic [DW-1:0] y_q,
  input logic [AW-1:0] p_q,
  input logic [AW-1:0] acc_q,
  input logic [STW-1:0] st_q
);
  logic mul_cmd, sum_cmd;
  assign mul_cmd = (op_code == OP_MCLR) || (op_code == OP_MADD) || (op_code == OP_MSUB);
  assign sum_cmd = (op_code == OP_MADD) || (op_code == OP_MSUB);

  assert_wrx_keeps_y_R2: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_WRX) |=> (x_q == $past(wr_data)) && (y_q == $past(y_q)));

  assert_wry_keeps_x_R3: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_WRY) |=> (y_q == $past(wr_data)) && (x_q == $past(x_q)));

  assert_clear_acc_R4: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_MCLR) |=> (acc_q == '0) && (st_q[15:12] == 4'b0010));

  assert_add_old_p_R5: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_MADD) |=> (acc_q == $past(acc_q) + $past(p_q)));

  assert_sub_old_p_R6: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_MSUB) |=> (acc_q == $past(acc_q) - $past(p_q)));

  assert_nz_flags_R7: assert property (@(posedge clk) disable iff (rst)
    sum_cmd |=> (st_q[FLG_N] == acc_q[AW-1]) && (st_q[FLG_Z] == (acc_q == '0)));

  assert_ctrl_kept_R8: assert property (@(posedge clk) disable iff (rst)
    mul_cmd |=> (st_q[11:0] == $past(st_q[11:0])));

  assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_NOP || op_code == OP_IDLE) |=>
      $stable(x_q) && $stable(y_q) && $stable(p_q) && $stable(acc_q) && $stable(st_q));

  assert_operands_loaded_R4: assert property (@(posedge clk) disable iff (rst)
    mul_cmd |=> (x_q == $past(rd_a)) && (y_q == $past(rd_b)));
endmodule

bind fmac_unit fmac_unit_chk #(.DW(DW)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .op_code (op_code),
  .wr_data (wr_data),
  .rd_a    (rd_a),
  .rd_b    (rd_b),
  .x_q     (x_q),
  .y_q     (y_q),
  .p_q     (p_q),
  .acc_q   (acc_q),
  .st_q    (st_q)
);

// File: tb/fmac_unit_tb.sv
module fmac_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  op_code = 3'd0;
  logic [15:0] wr_data = '0, rd_a = '0, rd_b = '0;
  logic [15:0] x_q, y_q, st_q;
  logic [31:0] p_q, acc_q;

  int total = 0;
  int bad   = 0;

  typedef struct {
    string       tag;
    logic [15:0] x, y, st;
    logic [31:0] p, a;
  } exp_t;
  exp_t sb_q[$];

  // reference model state
  logic [15:0] mx = '0, my = '0, mst = '0;
  logic [31:0] mp = '0, ma = '0;

  always #2 clk = ~clk;

  fmac_unit dut_i (
    .clk(clk), .rst(rst), .op_code(op_code), .wr_data(wr_data),
    .rd_a(rd_a), .rd_b(rd_b), .x_q(x_q), .y_q(y_q),
    .p_q(p_q), .acc_q(acc_q), .st_q(st_q)
  );

  function automatic logic [31:0] dbl_prod(logic [15:0] a, logic [15:0] b);
    longint t;
    t = longint'($signed(a)) * longint'($signed(b)) * 2;
    return t[31:0];
  endfunction

  task automatic drive(input logic [2:0] op, input logic [15:0] d,
                       input logic [15:0] a, input logic [15:0] b, input string tag);
    exp_t e;
    longint us, ss;
    logic [31:0] old_p;
    @(negedge clk);
    op_code = op; wr_data = d; rd_a = a; rd_b = b;
    old_p = mp;
    case (op)
      3'd1: begin mx = d; mp = dbl_prod(mx, my); end
      3'd2: begin my = d; mp = dbl_prod(mx, my); end
      3'd3: begin
        mx = a; my = b; mp = dbl_prod(a, b); ma = '0;
        mst[15:12] = 4'b0010;
      end
      3'd4, 3'd5: begin
        if (op == 3'd4) begin
          us = longint'(ma) + longint'(old_p);
          ss = longint'($signed(ma)) + longint'($signed(old_p));
          mst[12] = (us > 64'sh0FFFF_FFFF);
        end else begin
          us = longint'(ma) - longint'(old_p);
          ss = longint'($signed(ma)) - longint'($signed(old_p));
          mst[12] = (ma < old_p);
        end
        ma = us[31:0];
        mst[15] = ma[31];
        mst[14] = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
        mst[13] = (ma == 32'd0);
        mx = a; my = b; mp = dbl_prod(a, b);
      end
      3'd6: mst = d;
      default: ;
    endcase
    e.tag = tag; e.x = mx; e.y = my; e.p = mp; e.a = ma; e.st = mst;
    sb_q.push_back(e);
  endtask

  // monitor: compares one expected item per command edge
  always @(posedge clk) begin
    #1;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (x_q !== e.x || y_q !== e.y || p_q !== e.p || acc_q !== e.a || st_q !== e.st) begin
        bad++;
        $display("FAIL %s actual x=%h y=%h p=%h a=%h st=%h expected x=%h y=%h p=%h a=%h st=%h",
                 e.tag, x_q, y_q, p_q, acc_q, st_q, e.x, e.y, e.p, e.a, e.st);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    total++;
    if (x_q !== 16'h0 || y_q !== 16'h0 || p_q !== 32'h0 || acc_q !== 32'h0 || st_q !== 16'h0) begin
      bad++;
      $display("FAIL R1 actual x=%h y=%h p=%h a=%h st=%h expected all zero", x_q, y_q, p_q, acc_q, st_q);
    end
    drive(3'd1, 16'd3, 16'h0, 16'h0, "R2");
    drive(3'd2, 16'd5, 16'h0, 16'h0, "R3");
    drive(3'd1, 16'hFFFE, 16'h0, 16'h0, "R2");
    drive(3'd2, 16'h7FFF, 16'h0, 16'h0, "R3");
    drive(3'd6, 16'h0ABC, 16'h0, 16'h0, "R9");
    drive(3'd3, 16'h0, 16'h4000, 16'h4000, "R4");
    drive(3'd4, 16'h0, 16'h1000, 16'h0002, "R5");
    drive(3'd5, 16'h0, 16'hC000, 16'h0100, "R6");
    drive(3'd4, 16'h0, 16'h7FFF, 16'h7FFF, "R5");
    drive(3'd4, 16'h0, 16'h7FFF, 16'h7FFF, "R7");
    drive(3'd4, 16'h0, 16'h0001, 16'h0001, "R7");
    drive(3'd0, 16'hFFFF, 16'h1234, 16'h5678, "R9");
    drive(3'd7, 16'hFFFF, 16'h1234, 16'h5678, "R9");
    drive(3'd3, 16'h0, 16'h0123, 16'h0045, "R4");
    drive(3'd4, 16'h0, 16'h0123, 16'h0045, "R5");
    drive(3'd5, 16'h0, 16'h0001, 16'h0001, "R7");
    drive(3'd5, 16'h0, 16'h0000, 16'h0000, "R7");
    drive(3'd1, 16'h8000, 16'h0, 16'h0, "R10");
    drive(3'd2, 16'h8000, 16'h0, 16'h0, "R10");
    drive(3'd3, 16'h0, 16'h8000, 16'h8000, "R10");
    drive(3'd6, 16'h0555, 16'h0, 16'h0, "R9");
    for (int i = 0; i < 60; i++) begin
      logic [2:0] op;
      op = 3'd3 + 3'($urandom_range(0, 2));
      if (i % 9 == 0) op = 3'd3;
      drive(op, 16'h0, 16'($urandom), 16'($urandom), "R8");
    end
    @(negedge clk);
    op_code = 3'd0;
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule